// File: doc/BRIEF.md
# Four-Lane Comma-Pattern Deskew Aligner

This block takes four receive lanes whose 10-bit code groups are already character-aligned. It lines them up so that the lanes together deliver one 40-bit word on a common clock. Each lane keeps a short history of its most recent characters. A per-lane tap selects how far back in that history the lane's output is read, which sets the delay the lane adds.

Each lane is watched for a four-character synchronisation point made of comma code groups of both disparities. The detection is accepted only when every lane shows the point within a spread of two character times from the first lane to the last. The block then sets each lane's tap so that the characters following the point on all lanes leave the block in the same output word. It raises an aligned flag, which stays high until reset. A partial or over-skewed detection is dropped without touching the taps, and a later valid synchronisation point sets them again.

The sender is expected to follow the four-character point with two more comma characters of the point's last disparity. The tap change then only drops or repeats those fillers and never a data character.

Top module: `quad_lane_deskew`

## Requirements
- R1: Reset clears the aligned flag, word_valid and word_out, and sets every lane tap to the nominal depth. A character accepted on a lane then leaves on that lane's word_out slice three cycles after the cycle in which it was presented.
- R2: A lane detects the synchronisation point when its four most recently accepted characters, oldest first, are P,P,N,N or N,N,P,P. Here P = 10'b1100000101 (positive disparity comma) and N = 10'b0011111010 (negative disparity comma). Both orders lead to alignment.
- R3: When all four lanes detect the point and the first and last detections are at most two cycles apart, aligned is high two cycles after the cycle in which the last lane presented its fourth pattern character. It is still low one cycle after that cycle if it was low before.
- R4: After alignment, the nth character after the two fillers appears on all four lanes in the same output word. The first such word comes five cycles after the last lane's fourth pattern character was presented.
- R5: If the detections are spread over more than two cycles, they are discarded. The aligned flag and all lane taps keep their previous values.
- R6: If one or more lanes never show the point within the window, no alignment happens and the detector re-arms for a later complete synchronisation point.
- R7: Once set, aligned stays high until reset. A new valid synchronisation point with different skew moves the taps to match the new skew.
- R8: The tap change drops or repeats only comma fillers. Data characters on every lane leave in order, each exactly once, with no gaps between successive words.
- R9: A character presented while its lane's valid is low is not stored and never reaches word_out. word_valid is high in the cycle after all four lane valids were high, and low otherwise.
- R10: Lane k occupies bits [10k+9:10k] of both lane_data and word_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_valid | input | 4 | Per-lane strobe: the character on the lane is accepted |
| lane_data | input | 40 | Four 10-bit code groups, lane k at bits [10k+9:10k] |
| word_out | output | 40 | Deskewed 40-bit word, lane k at bits [10k+9:10k] |
| word_valid | output | 1 | All four lanes were valid in the previous cycle |
| aligned | output | 1 | A synchronisation point has set the lane taps since reset |

## Verification
A character presented in cycle c on a lane with tap depth d is due on that lane's slice of word_out in cycle c+2+d. The driver pushes each data character onto a queue with exactly that due cycle, using the depth in force when the character leaves. The monitor compares each queued item only in its due cycle. The aligned flag is due two cycles after the last lane's fourth pattern character, so the bench samples it one cycle before and in that cycle. word_valid is checked one cycle after a dropped strobe. All sampling happens on the falling edge, half a cycle after the registers change.

// File: rtl/qld_pkg.sv
// Package: code constants and the sync-point matcher shared by the deskew aligner.
// Assumes 10-bit code groups; the comma encodings fix that width.
package qld_pkg;

    localparam int SYM_W   = 10;
    localparam int PAT_LEN = 4;

    localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

    // True when four characters (oldest first) form a sync point of either order.
    function automatic logic sync_match(
        input logic [SYM_W-1:0] c3,
        input logic [SYM_W-1:0] c2,
        input logic [SYM_W-1:0] c1,
        input logic [SYM_W-1:0] c0
    );
        return ((c3 == COMMA_POS) && (c2 == COMMA_POS) && (c1 == COMMA_NEG) && (c0 == COMMA_NEG)) ||
               ((c3 == COMMA_NEG) && (c2 == COMMA_NEG) && (c1 == COMMA_POS) && (c0 == COMMA_POS));
    endfunction

endpackage

// File: rtl/qld_lane_buf.sv
// Lane buffer: keeps the last DEPTH accepted characters of one lane and
// registers the character selected by the tap as the lane's output.
// Flags a sync point one cycle after its fourth character is accepted.
// Assumes DEPTH >= PAT_LEN and a tap value below DEPTH.
module qld_lane_buf
    import qld_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [SYM_W-1:0] data,
    input  logic [TAP_W-1:0] tap,
    output logic             hit,
    output logic [SYM_W-1:0] sym_out
);

    logic [SYM_W-1:0] hist [DEPTH];
    logic             fresh;

    // Shift an accepted character into the history; note whether one arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b0;
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else begin
            fresh <= valid;
            if (valid) begin
                hist[0] <= data;
                for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
            end
        end
    end

    // Register the tapped history entry as this lane's output character.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_out <= '0;
        else        sym_out <= hist[tap];
    end

    // Sync point present in the newest four characters, counted once on arrival.
    assign hit = fresh && sync_match(hist[PAT_LEN-1], hist[PAT_LEN-2], hist[PAT_LEN-3], hist[0]);

endmodule

// File: rtl/qld_sync_window.sv
// Sync window: gathers per-lane sync detections inside a window of SPREAD
// cycles after the first one. When every lane has reported, it sets each
// lane's tap to the number of cycles that lane was early, and raises the
// sticky aligned flag. An incomplete window is discarded and re-armed.
// Assumes SPREAD < 2**TAP_W and SPREAD < the lane history depth.
module qld_sync_window #(
    parameter int LANES   = 4,
    parameter int SPREAD  = 2,
    parameter int TAP_W   = 2,
    parameter int NOMINAL = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       hit,
    output logic [LANES*TAP_W-1:0] tap_flat,
    output logic                   aligned
);

    localparam int IDX_W = $clog2(SPREAD + 1);

    logic                 open;
    logic [IDX_W-1:0]     age;
    logic [LANES-1:0]     seen;
    logic [IDX_W-1:0]     stamp     [LANES];
    logic [IDX_W-1:0]     stamp_now [LANES];
    logic [IDX_W-1:0]     cur_idx;
    logic [LANES-1:0]     seen_now;
    logic                 complete;

    // Current window position, lanes reported so far and their arrival stamps.
    always_comb begin
        cur_idx  = open ? age : '0;
        seen_now = (open ? seen : '0) | hit;
        complete = &seen_now;
        for (int i = 0; i < LANES; i++)
            stamp_now[i] = (open && seen[i]) ? stamp[i] : cur_idx;
    end

    // Window control: open on the first hit, fire when complete, drop when late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open    <= 1'b0;
            age     <= '0;
            seen    <= '0;
            aligned <= 1'b0;
            for (int i = 0; i < LANES; i++) begin
                stamp[i]                     <= '0;
                tap_flat[i*TAP_W +: TAP_W]   <= TAP_W'(NOMINAL);
            end
        end else if (open || (|hit)) begin
            if (complete) begin
                open    <= 1'b0;
                aligned <= 1'b1;
                for (int i = 0; i < LANES; i++)
                    tap_flat[i*TAP_W +: TAP_W] <= TAP_W'(cur_idx - stamp_now[i]);
            end else if (cur_idx == IDX_W'(SPREAD)) begin
                open <= 1'b0;
            end else begin
                open <= 1'b1;
                age  <= cur_idx + 1'b1;
                seen <= seen_now;
                for (int i = 0; i < LANES; i++) stamp[i] <= stamp_now[i];
            end
        end
    end

endmodule

// File: rtl/quad_lane_deskew.sv
// Top: four-lane deskew aligner. One lane buffer per lane feeds a shared
// sync window; the window's taps set each lane's delay so that the
// characters after a sync point leave all lanes in one output word.
// Assumes one character per lane per cycle while valid, on a common clock.
module quad_lane_deskew
    import qld_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DEPTH  = 4,
    parameter int SPREAD = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       lane_valid,
    input  logic [LANES*SYM_W-1:0] lane_data,
    output logic [LANES*SYM_W-1:0] word_out,
    output logic                   word_valid,
    output logic                   aligned
);

    localparam int TAP_W   = $clog2(DEPTH);
    localparam int NOMINAL = SPREAD / 2;

    logic [LANES-1:0]       lane_hit;
    logic [LANES*TAP_W-1:0] lane_tap;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qld_lane_buf #(
            .DEPTH (DEPTH),
            .TAP_W (TAP_W)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (lane_valid[g]),
            .data    (lane_data[g*SYM_W +: SYM_W]),
            .tap     (lane_tap[g*TAP_W +: TAP_W]),
            .hit     (lane_hit[g]),
            .sym_out (word_out[g*SYM_W +: SYM_W])
        );
    end

    qld_sync_window #(
        .LANES   (LANES),
        .SPREAD  (SPREAD),
        .TAP_W   (TAP_W),
        .NOMINAL (NOMINAL)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (lane_hit),
        .tap_flat (lane_tap),
        .aligned  (aligned)
    );

    // Word is valid when every lane delivered a character in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) word_valid <= 1'b0;
        else        word_valid <= &lane_valid;
    end

endmodule

// File: rtl/qld_checker.sv
// Checker: temporal properties of the deskew aligner, bound to the top.
// Observes the lane strobes, detections, taps and flags only.
module qld_checker #(
    parameter int LANES  = 4,
    parameter int TAP_W  = 2,
    parameter int SPREAD = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       lane_valid,
    input logic [LANES-1:0]       lane_hit,
    input logic [LANES*TAP_W-1:0] lane_tap,
    input logic                   aligned,
    input logic                   word_valid
);

    // R7: aligned never falls while out of reset.
    a_r7_aligned_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |=> aligned)
        else $error("a_r7_aligned_sticky");

    // R3: aligned only rises right after a cycle with a lane detection.
    a_r3_rise_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(|lane_hit))
        else $error("a_r3_rise_after_hit");

    // R5: without a detection the taps cannot move.
    a_r5_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lane_hit) |=> $stable(lane_tap))
        else $error("a_r5_taps_hold");

    // R9: word_valid follows the AND of all lane strobes by one cycle.
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (&lane_valid) |=> word_valid)
        else $error("a_r9_valid_follow");

    a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_valid) |=> !word_valid)
        else $error("a_r9_valid_drop");

    // R4: every tap stays within the skew window.
    for (genvar g = 0; g < LANES; g++) begin : g_rng
        a_r4_tap_range: assert property (@(posedge clk) disable iff (!rst_n)
            lane_tap[g*TAP_W +: TAP_W] <= TAP_W'(SPREAD))
            else $error("a_r4_tap_range lane %0d", g);
    end

endmodule

bind quad_lane_deskew qld_checker #(
    .LANES  (LANES),
    .TAP_W  (TAP_W),
    .SPREAD (SPREAD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_valid (lane_valid),
    .lane_hit   (lane_hit),
    .lane_tap   (lane_tap),
    .aligned    (aligned),
    .word_valid (word_valid)
);

// File: tb/quad_lane_deskew_bench.sv
// Scoreboard bench: the driver queues each data character with the cycle
// it is due on word_out; the monitor compares items in their due cycle.
module quad_lane_deskew_bench;

    localparam int NPRE  = 4;
    localparam int NDATA = 8;
    localparam logic [9:0] KN = 10'b0011111010;
    localparam logic [9:0] KP = 10'b1100000101;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  lane_valid;
    logic [39:0] lane_data;
    logic [39:0] word_out;
    logic        word_valid;
    logic        aligned;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int mtap[4] = '{1, 1, 1, 1};

    typedef struct {
        int         due;
        int         lane;
        logic [9:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_lane_deskew u_quad_lane_deskew (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_valid (lane_valid),
        .lane_data  (lane_data),
        .word_out   (word_out),
        .word_valid (word_valid),
        .aligned    (aligned)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Monitor: compare every queued lane character in its due cycle.
    always @(negedge clk) begin
        for (int q = exp_q.size() - 1; q >= 0; q--) begin
            if (exp_q[q].due == cyc) begin
                check(word_out[exp_q[q].lane*10 +: 10] == exp_q[q].val, exp_q[q].req,
                      $sformatf("lane %0d char", exp_q[q].lane),
                      40'(word_out[exp_q[q].lane*10 +: 10]), 40'(exp_q[q].val));
                exp_q.delete(q);
            end
        end
    end

    function automatic logic [9:0] lane_char(input int lane, input int j, input int t,
                                             input bit pol, input bit sends);
        if (j < 0) return 10'h200 | 10'((lane * 64 + t) & 255);
        if (j < 6) begin
            if (!sends) return 10'h280 | 10'(j);
            if (j < 2)  return pol ? KN : KP;
            return pol ? KP : KN;
        end
        return 10'h100 | 10'((lane << 6) | ((j - 6) & 63));
    endfunction

    // Driver: one sync scenario with per-lane skew s0..s3 (in characters).
    task automatic run_sync(input int s0, input int s1, input int s2, input int s3,
                            input bit pol, input bit [3:0] mask, input bit expect_align,
                            input string preq, input string dreq);
        int s[4];
        int ntap[4];
        int smax;
        int k_t;
        bit was_al;
        s = '{s0, s1, s2, s3};
        smax = 0;
        for (int i = 0; i < 4; i++) if (s[i] > smax) smax = s[i];
        for (int i = 0; i < 4; i++) ntap[i] = expect_align ? (smax - s[i]) : mtap[i];
        k_t = NPRE + smax + 3;
        was_al = 1'b0;
        for (int t = 0; t < NPRE + smax + 6 + NDATA + 4; t++) begin
            @(negedge clk);
            if (t == 0) was_al = aligned;
            if (expect_align && !was_al && t == k_t + 1)
                check(aligned == 1'b0, "R3", "aligned one cycle after last pattern char", 40'(aligned), 40'd0);
            if (expect_align && t == k_t + 2)
                check(aligned == 1'b1, "R3", "aligned two cycles after last pattern char", 40'(aligned), 40'd1);
            for (int i = 0; i < 4; i++) begin
                int j;
                logic [9:0] ch;
                j = t - NPRE - s[i];
                ch = lane_char(i, j, t, pol, mask[i]);
                lane_data[i*10 +: 10] = ch;
                if (j < 0)
                    exp_q.push_back('{cyc + 2 + mtap[i], i, ch, preq});
                else if (j >= 6 && j < 6 + NDATA)
                    exp_q.push_back('{cyc + 2 + ntap[i], i, ch, dreq});
            end
        end
        check(aligned == (expect_align | was_al), expect_align ? "R7" : "R5",
              "aligned after scenario", 40'(aligned), 40'(expect_align | was_al));
        for (int i = 0; i < 4; i++) mtap[i] = ntap[i];
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        lane_valid = 4'hF;
        lane_data  = '0;
        repeat (3) @(negedge clk);
        check(aligned == 1'b0,    "R1", "aligned in reset",    40'(aligned), 40'd0);
        check(word_valid == 1'b0, "R1", "word_valid in reset", 40'(word_valid), 40'd0);
        check(word_out == 40'd0,  "R1", "word_out in reset",   word_out, 40'd0);
        rst_n = 1'b1;

        // R6: lane 3 never shows the point; nominal latency checked on pre-data (R1).
        run_sync(0, 0, 0, 0, 1'b0, 4'b0111, 1'b0, "R1", "R6");
        // R5: spread of three characters is discarded before any alignment.
        run_sync(0, 3, 1, 2, 1'b0, 4'b1111, 1'b0, "R10", "R5");
        // R2/R4/R8: P,P,N,N order with skew inside the window aligns all lanes.
        run_sync(2, 0, 1, 0, 1'b0, 4'b1111, 1'b1, "R10", "R4");
        // R2/R7: N,N,P,P order with new skew re-applies the taps.
        run_sync(0, 1, 2, 1, 1'b1, 4'b1111, 1'b1, "R10", "R8");
        // R5/R7: over-skewed point after alignment leaves taps and flag alone.
        run_sync(3, 0, 0, 1, 1'b1, 4'b1111, 1'b0, "R10", "R5");
        // R7: zero skew aligns again with all taps at the shallowest depth.
        run_sync(0, 0, 0, 0, 1'b0, 4'b1111, 1'b1, "R10", "R2");

        // R9: a character with its strobe low is neither stored nor output.
        @(negedge clk);
        lane_valid = 4'b1101;
        lane_data[10 +: 10] = 10'h3AA;
        @(negedge clk);
        check(word_valid == 1'b0, "R9", "word_valid after dropped strobe", 40'(word_valid), 40'd0);
        lane_valid = 4'hF;
        lane_data[10 +: 10] = 10'h155;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            check(word_out[10 +: 10] != 10'h3AA, "R9", "unaccepted char on lane 1",
                  40'(word_out[10 +: 10]), 40'h155);
            check(word_valid == 1'b1, "R9", "word_valid with all strobes", 40'(word_valid), 40'd1);
        end

        check(exp_q.size() == 0, "R4", "scoreboard drained", 40'(exp_q.size()), 40'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule